// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Deferral

This block sits inside a DDR SDRAM controller and decides when refresh commands are due. A free-running interval timer adds one unit of refresh debt each time the average refresh period elapses. While debt is outstanding the block raises a low-priority request to the command arbiter. The arbiter answers with a one-cycle grant once it has closed every bank and issued the refresh, and each grant pays off one unit of debt.

Refreshes may be put off and stacked up, but never beyond a ceiling of eight. When the stack reaches seven the block raises an urgent request, which tells the arbiter to close all banks and refresh at once. If an interval still expires with eight owed, a sticky error flag is set. After every granted refresh, row activation is blocked for the refresh cycle time. While a self-refresh input is high, the interval timer and the debt hold still. When that input falls, command permissions stay low until the exit delays for non-read and read commands have run out.

All cycle counts are derived from a clock-period parameter by rounding each time up, so the same RTL serves any clock rate. The values in the requirements below assume a 4000 ps clock.

Top module: `ref_refresh_sched`

## Requirements
- R1: Debt rises by one each time IVL = ceil(TREFI_PS/CLK_PERIOD_PS) clock edges have run with self_refresh low. That is 1950 edges at 4000 ps. The first rise happens at edge 1950 after reset is released, and debt is still 0 after edge 1949.
- R2: A ref_grant is accepted only when refresh_debt is non-zero and self_refresh is low, and then lowers the debt by one. Any other grant changes neither the debt nor act_allowed. A grant accepted in the same cycle as an interval expiry leaves the debt unchanged.
- R3: refresh_req is 1 exactly when debt is at least 1 and self_refresh is low. refresh_urgent is 1 exactly when debt is at least URGENT_LEVEL (7) and self_refresh is low.
- R4: Debt saturates at MAX_DEBT (8). An expiry that arrives with debt 8 and no accepted grant sets debt_overflow, which stays set until reset.
- R5: After an accepted grant, act_allowed is 0 until RFC = ceil(TRFC_PS/CLK_PERIOD_PS) further edges have passed (17 at 4000 ps). It is 0 after the 16th such edge and 1 after the 17th.
- R6: While self_refresh is high, debt and the interval position are frozen and refresh_req is 0. After exit, counting resumes from the frozen position.
- R7: cmd_allowed, rd_allowed and act_allowed are 0 while self_refresh is high and in the cycle it first reads low. Take E0 as the first edge that samples self_refresh low. rd_allowed returns to 1 XSRD (10) edges after E0. cmd_allowed, which covers all non-read commands including activate, returns to 1 XSNR = ceil(TXSNR_PS/CLK_PERIOD_PS) edges after E0 (19 at 4000 ps).
- R8: During and right after reset: debt 0, refresh_req, refresh_urgent and debt_overflow 0, and all three allowed outputs 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| self_refresh | input | 1 | High while the device is in self-refresh; freezes the scheduler |
| ref_grant | input | 1 | One-cycle pulse from the arbiter: a refresh was issued |
| refresh_req | output | 1 | Low-priority refresh wanted |
| refresh_urgent | output | 1 | Debt near the ceiling; refresh immediately |
| refresh_debt | output | $clog2(MAX_DEBT+1) (4) | Number of refreshes currently owed |
| debt_overflow | output | 1 | Sticky: an interval expired with the debt at its ceiling |
| act_allowed | output | 1 | Row activation permitted |
| cmd_allowed | output | 1 | Non-read commands permitted |
| rd_allowed | output | 1 | Read commands permitted |

## Verification
The debt function is driven by a table of phases: pure waits that end exactly on an expiry edge and one edge before it, bursts of grants that drain the debt, grants with nothing owed, and a long wait that pushes past the ceiling. Together these separate an off-by-one interval, missing saturation, a non-sticky overflow, and grants that are wrongly accepted. Directed phases then time the activation blackout edge by edge and put a grant on the same edge as an expiry. They also hold self-refresh across an expiry time with a grant pulse inside it, then time both exit delays and the resumed interval position. This distinguishes a freeze from a timer restart.

// File: rtl/ref_sched_pkg.sv
package ref_sched_pkg;

   localparam int unsigned HOLD_RFC  = 0;
   localparam int unsigned HOLD_XSNR = 1;
   localparam int unsigned HOLD_XSRD = 2;
   localparam int unsigned NUM_HOLD  = 3;

   // Round a picosecond duration up to whole clock cycles.
   function automatic int unsigned ceil_cycles(input int unsigned dur_ps,
                                               input int unsigned per_ps);
      return (dur_ps + per_ps - 1) / per_ps;
   endfunction

   // Select the load value for one hold-off timer slot.
   function automatic int unsigned hold_load(input int unsigned idx,
                                             input int unsigned rfc,
                                             input int unsigned xsnr,
                                             input int unsigned xsrd);
      case (idx)
         HOLD_RFC:  return rfc;
         HOLD_XSNR: return xsnr;
         default:   return xsrd;
      endcase
   endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
   parameter int unsigned INTERVAL_CYC = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic freeze,
   output logic expire
);
   localparam int unsigned CNT_W = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_CYC - 1);

   logic [CNT_W-1:0] pos;

   initial begin
      if (INTERVAL_CYC < 2) $error("interval must span at least two cycles");
   end

   assign expire = !freeze && (pos == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (!freeze) begin
         pos <= (pos == LAST) ? '0 : pos + CNT_W'(1);
      end
   end
endmodule

// File: rtl/ref_debt_tracker.sv
module ref_debt_tracker #(
   parameter int unsigned MAX_DEBT     = 8,
   parameter int unsigned URGENT_LEVEL = 7,
   parameter int unsigned DEBT_W       = $clog2(MAX_DEBT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              expire,
   input  logic              take,
   output logic [DEBT_W-1:0] debt,
   output logic              urgent_lvl,
   output logic              overflow
);
   localparam logic [DEBT_W-1:0] CEIL = DEBT_W'(MAX_DEBT);
   localparam logic [DEBT_W-1:0] URG  = DEBT_W'(URGENT_LEVEL);

   logic at_ceil;
   logic take_ok;

   assign at_ceil    = (debt == CEIL);
   assign take_ok    = take && (debt != '0);
   assign urgent_lvl = (debt >= URG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         debt     <= '0;
         overflow <= 1'b0;
      end else begin
         if (expire && !take_ok) begin
            if (!at_ceil) debt <= debt + DEBT_W'(1);
            else          overflow <= 1'b1;
         end else if (take_ok && !expire) begin
            debt <= debt - DEBT_W'(1);
         end
      end
   end
endmodule

// File: rtl/ref_hold_timer.sv
module ref_hold_timer #(
   parameter int unsigned LOAD_CYC = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   generate
      if (LOAD_CYC == 0) begin : g_none
         logic unused_in;
         assign unused_in = ^{clk, rst_n, start};
         assign busy = 1'b0;
      end else begin : g_cnt
         localparam int unsigned W = $clog2(LOAD_CYC + 1);
         logic [W-1:0] left;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             left <= '0;
            else if (start)         left <= W'(LOAD_CYC);
            else if (left != '0)    left <= left - W'(1);
         end
         assign busy = (left != '0);
      end
   endgenerate
endmodule

// File: rtl/ref_refresh_sched.sv
module ref_refresh_sched
   import ref_sched_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_PS = 5000,
   parameter int unsigned TREFI_PS      = 7_800_000,
   parameter int unsigned TRFC_PS       = 65_000,
   parameter int unsigned TXSNR_PS      = 75_000,
   parameter int unsigned XSRD_CYC      = 10,
   parameter int unsigned MAX_DEBT      = 8,
   parameter int unsigned URGENT_LEVEL  = 7
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          self_refresh,
   input  logic                          ref_grant,
   output logic                          refresh_req,
   output logic                          refresh_urgent,
   output logic [$clog2(MAX_DEBT+1)-1:0] refresh_debt,
   output logic                          debt_overflow,
   output logic                          act_allowed,
   output logic                          cmd_allowed,
   output logic                          rd_allowed
);
   localparam int unsigned DEBT_W   = $clog2(MAX_DEBT + 1);
   localparam int unsigned IVL_CYC  = ceil_cycles(TREFI_PS, CLK_PERIOD_PS);
   localparam int unsigned RFC_CYC  = ceil_cycles(TRFC_PS, CLK_PERIOD_PS);
   localparam int unsigned XSNR_CYC = ceil_cycles(TXSNR_PS, CLK_PERIOD_PS);

   initial begin
      if (CLK_PERIOD_PS == 0) $error("clock period must be non-zero");
      if (MAX_DEBT < 2) $error("posting ceiling must be at least two");
      if (URGENT_LEVEL == 0 || URGENT_LEVEL > MAX_DEBT)
         $error("urgent level must lie within 1..MAX_DEBT");
   end

   logic                expire;
   logic                accept;
   logic                urgent_lvl;
   logic                sr_q;
   logic                sr_block;
   logic [NUM_HOLD-1:0] hold_start;
   logic [NUM_HOLD-1:0] hold_busy;

   assign accept = ref_grant && !self_refresh && (refresh_debt != '0);

   ref_interval_timer #(.INTERVAL_CYC(IVL_CYC)) u_ivl (
      .clk    (clk),
      .rst_n  (rst_n),
      .freeze (self_refresh),
      .expire (expire)
   );

   ref_debt_tracker #(
      .MAX_DEBT     (MAX_DEBT),
      .URGENT_LEVEL (URGENT_LEVEL),
      .DEBT_W       (DEBT_W)
   ) u_debt (
      .clk        (clk),
      .rst_n      (rst_n),
      .expire     (expire),
      .take       (accept),
      .debt       (refresh_debt),
      .urgent_lvl (urgent_lvl),
      .overflow   (debt_overflow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= 1'b0;
      else        sr_q <= self_refresh;
   end

   assign hold_start[HOLD_RFC]  = accept;
   assign hold_start[HOLD_XSNR] = sr_q && !self_refresh;
   assign hold_start[HOLD_XSRD] = sr_q && !self_refresh;

   for (genvar i = 0; i < NUM_HOLD; i++) begin : g_hold
      ref_hold_timer #(
         .LOAD_CYC (hold_load(i, RFC_CYC, XSNR_CYC, XSRD_CYC))
      ) u_tmr (
         .clk   (clk),
         .rst_n (rst_n),
         .start (hold_start[i]),
         .busy  (hold_busy[i])
      );
   end

   assign sr_block       = self_refresh || sr_q;
   assign refresh_req    = !self_refresh && (refresh_debt != '0);
   assign refresh_urgent = !self_refresh && urgent_lvl;
   assign cmd_allowed    = !sr_block && !hold_busy[HOLD_XSNR];
   assign rd_allowed     = !sr_block && !hold_busy[HOLD_XSRD];
   assign act_allowed    = cmd_allowed && !hold_busy[HOLD_RFC];

endmodule

// File: rtl/ref_sched_chk.sv
module ref_sched_chk #(
   parameter int unsigned MAX_DEBT = 8,
   parameter int unsigned DEBT_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              self_refresh,
   input logic              ref_grant,
   input logic              refresh_req,
   input logic              refresh_urgent,
   input logic [DEBT_W-1:0] refresh_debt,
   input logic              debt_overflow,
   input logic              act_allowed,
   input logic              cmd_allowed,
   input logic              rd_allowed
);
   AST_DEBT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
      int'(refresh_debt) <= int'(MAX_DEBT)); // R4

   AST_DEBT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (int'(refresh_debt) - int'($past(refresh_debt)) <= 1) &&
               (int'($past(refresh_debt)) - int'(refresh_debt) <= 1)); // R2

   AST_URGENT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_urgent |-> refresh_req); // R3

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      debt_overflow |=> debt_overflow); // R4

   AST_BLACKOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_grant && refresh_req) |=> !act_allowed); // R5

   AST_SR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      self_refresh |=> $stable(refresh_debt)); // R6

   AST_SR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      self_refresh |-> !(cmd_allowed || rd_allowed || act_allowed)); // R7

   AST_EXIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(self_refresh) |-> (!cmd_allowed && !rd_allowed)); // R7

   AST_ACT_UNDER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      act_allowed |-> cmd_allowed); // R7
endmodule

bind ref_refresh_sched ref_sched_chk #(
   .MAX_DEBT (MAX_DEBT),
   .DEBT_W   ($clog2(MAX_DEBT + 1))
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .self_refresh   (self_refresh),
   .ref_grant      (ref_grant),
   .refresh_req    (refresh_req),
   .refresh_urgent (refresh_urgent),
   .refresh_debt   (refresh_debt),
   .debt_overflow  (debt_overflow),
   .act_allowed    (act_allowed),
   .cmd_allowed    (cmd_allowed),
   .rd_allowed     (rd_allowed)
);

// File: tb/ref_refresh_sched_tb_top.sv
module ref_refresh_sched_tb_top;
   localparam int NROWS = 11;
   // columns: cycles, grant level, expected debt, expected urgent, expected overflow
   localparam int VEC [NROWS][5] = '{
      '{1949,  0, 0, 0, 0},
      '{1,     0, 1, 0, 0},
      '{9750,  0, 6, 0, 0},
      '{1950,  0, 7, 1, 0},
      '{1950,  0, 8, 1, 0},
      '{3,     1, 5, 0, 0},
      '{1947,  0, 6, 0, 0},
      '{6,     1, 0, 0, 0},
      '{2,     1, 0, 0, 0},
      '{17550, 0, 8, 1, 1},
      '{8,     1, 0, 0, 1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       self_refresh = 1'b0;
   logic       ref_grant = 1'b0;
   logic       refresh_req, refresh_urgent, debt_overflow;
   logic       act_allowed, cmd_allowed, rd_allowed;
   logic [3:0] refresh_debt;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   ref_refresh_sched #(.CLK_PERIOD_PS(4000)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .self_refresh   (self_refresh),
      .ref_grant      (ref_grant),
      .refresh_req    (refresh_req),
      .refresh_urgent (refresh_urgent),
      .refresh_debt   (refresh_debt),
      .debt_overflow  (debt_overflow),
      .act_allowed    (act_allowed),
      .cmd_allowed    (cmd_allowed),
      .rd_allowed     (rd_allowed)
   );

   task automatic chk(input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   task automatic run(input int n, input logic g);
      ref_grant = g;
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
      ref_grant = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R8 reset debt", refresh_debt, 0);
      chk("R8 reset req", refresh_req, 0);
      chk("R8 reset urgent", refresh_urgent, 0);
      chk("R8 reset overflow", debt_overflow, 0);
      chk("R8 reset act", act_allowed, 1);
      chk("R8 reset cmd", cmd_allowed, 1);
      chk("R8 reset rd", rd_allowed, 1);
      rst_n = 1'b1;

      // table walk: R1 interval, R2 grants, R3 request levels, R4 ceiling
      for (int r = 0; r < NROWS; r++) begin
         run(VEC[r][0], VEC[r][1] != 0);
         chk($sformatf("R1/R2 row %0d debt", r), refresh_debt, VEC[r][2]);
         chk($sformatf("R3 row %0d req", r), refresh_req, (VEC[r][2] != 0) ? 1 : 0);
         chk($sformatf("R3 row %0d urgent", r), refresh_urgent, VEC[r][3]);
         chk($sformatf("R4 row %0d overflow", r), debt_overflow, VEC[r][4]);
      end

      // R5 activation blackout after the last accepted grant
      chk("R5 act right after grant", act_allowed, 0);
      run(16, 1'b0);
      chk("R5 act after 16 edges", act_allowed, 0);
      run(1, 1'b0);
      chk("R5 act after 17 edges", act_allowed, 1);

      // R2 grant with no debt is ignored
      run(1, 1'b1);
      chk("R2 idle grant act", act_allowed, 1);
      chk("R2 idle grant debt", refresh_debt, 0);

      // R2 grant on the same edge as an expiry
      run(3865, 1'b0);
      chk("R1 debt before coincident edge", refresh_debt, 1);
      run(1, 1'b1);
      chk("R2 coincident expiry and grant", refresh_debt, 1);
      chk("R5 coincident grant blackout", act_allowed, 0);

      // R6/R7 self-refresh freeze
      self_refresh = 1'b1;
      #1;
      chk("R6 req in self refresh", refresh_req, 0);
      chk("R7 cmd in self refresh", cmd_allowed, 0);
      chk("R7 rd in self refresh", rd_allowed, 0);
      chk("R7 act in self refresh", act_allowed, 0);
      run(2500, 1'b0);
      run(1, 1'b1);
      run(2499, 1'b0);
      chk("R6 debt frozen", refresh_debt, 1);
      self_refresh = 1'b0;
      #1;
      chk("R7 cmd at exit cycle", cmd_allowed, 0);
      chk("R7 rd at exit cycle", rd_allowed, 0);
      run(1, 1'b0);
      chk("R7 cmd after E0", cmd_allowed, 0);
      run(9, 1'b0);
      chk("R7 rd after 9", rd_allowed, 0);
      run(1, 1'b0);
      chk("R7 rd after 10", rd_allowed, 1);
      chk("R7 cmd after 10", cmd_allowed, 0);
      run(8, 1'b0);
      chk("R7 cmd after 18", cmd_allowed, 0);
      chk("R7 act after 18", act_allowed, 0);
      run(1, 1'b0);
      chk("R7 cmd after 19", cmd_allowed, 1);
      chk("R7 act after 19", act_allowed, 1);
      chk("R6 req after exit", refresh_req, 1);
      run(1929, 1'b0);
      chk("R6 resumed position, before expiry", refresh_debt, 1);
      run(1, 1'b0);
      chk("R6 resumed position, at expiry", refresh_debt, 2);

      // R4/R8 reset clears the sticky flag
      run(1, 1'b0);
      rst_n = 1'b0;
      #1;
      chk("R4 overflow cleared by reset", debt_overflow, 0);
      chk("R8 debt cleared by reset", refresh_debt, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule